// File: doc/BRIEF.md
# Oversampled Serial Receiver Front End

This block recovers characters from an asynchronous serial line. A one-cycle sample tick arrives at sixteen times the bit rate. The block passes the line through a synchroniser and watches for a falling edge. It then confirms the start bit at its centre, eight ticks later. If the line has already returned high by then, the low pulse is treated as noise and the block goes back to waiting. No character comes out of a rejected start.

Once a start bit is confirmed, the block samples a new bit every sixteen ticks: first the eight data bits, least significant first, then the stop bit. When it samples the stop bit it presents the assembled byte with a one-cycle valid strobe and a framing-error flag. The byte and the flag are held until the next character replaces them. After each character the block waits for the line to be high before it looks for another start edge.

The control is one state machine with five states:
- `S_IDLE` waits for a low line.
- `S_START` counts to the start-bit centre.
- `S_DATA` shifts in the data bits.
- `S_STOP` samples the stop bit and delivers the character.
- `S_WAIT_HIGH` holds until the line is high.

The transitions are:
- IDLE→START on a low line.
- START→DATA on a low sample at the eighth tick.
- START→IDLE on a high sample at the eighth tick.
- DATA→STOP after the last data sample.
- STOP→WAIT_HIGH on the stop sample.
- WAIT_HIGH→IDLE once the line is high.

Top module: `uart_rx_front`

## Requirements
- R1: After reset, `data_valid` is 0, `data_out` is 0x00 and `frame_err` is 0.
- R2: A frame is one low start bit, then eight data bits with the least significant bit first, then a stop bit, each lasting 16 ticks. Such a frame produces exactly one `data_valid` pulse, one clock long, with `data_out` equal to the transmitted byte.
- R3: A low pulse shorter than half a bit period (fewer than 8 ticks) produces no character.
- R4: Each data bit and the stop bit is sampled near its centre. Driving the opposite value during the first 3 ticks and the last 3 ticks of every data bit does not change the received byte.
- R5: If the stop-bit sample is 0, `frame_err` is 1 and the byte is still delivered. If it is 1, `frame_err` is 0.
- R6: After a character, no new start is accepted until the line has been seen high. A line held low after a framing error produces no further character.
- R7: `data_out` and `frame_err` keep their values between characters, including across a rejected noise pulse.
- R8: A frame whose start bit follows the previous stop bit with no idle gap is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle sample enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| data_out | output | 8 | Last received byte |
| data_valid | output | 1 | One-cycle strobe when a character completes |
| frame_err | output | 1 | Stop-bit sample of the last character was 0 |

## Verification
The bench sends a low pulse of 4 ticks and one of 5 ticks. A receiver that skips the start-bit recheck would build a false character from either pulse. It also sends a frame whose data bits are wrong near both edges of each bit. Sampling off-centre would corrupt that byte. After a framing error it holds the line low for several bit times. A receiver that rearms without first seeing the line high would turn that low stretch into a 0x00 character. Back-to-back frames and a stop bit of 0 check that the stop sample is both timed and reported correctly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_WAIT_HIGH
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
// Synchronises the asynchronous line into the clock domain; resets to idle-high.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_count.sv
// Counts sample ticks within a bit; flags the mid-bit and end-of-bit ticks.
module rx_tick_count #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic hit_mid,
    output logic hit_end
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] END_LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (hit_end)    cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    assign hit_mid = tick && (cnt == MID_LAST);
    assign hit_end = tick && (cnt == END_LAST);
endmodule

// File: rtl/rx_shift.sv
// Right-shifting register: the first bit in ends in the least significant position.
module rx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {bit_in, q[WIDTH-1:1]};
    end
endmodule

// File: rtl/uart_rx_front.sv
module uart_rx_front
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 data_valid,
    output logic                 frame_err
);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

    rx_state_e            state, nxt;
    logic                 rx_s;
    logic                 hit_mid, hit_end;
    logic                 cnt_clr;
    logic                 shift_en;
    logic [DATA_BITS-1:0] shift_q;
    logic [IW-1:0]        bit_idx;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    rx_tick_count #(.OSR(OSR)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (cnt_clr),
        .hit_mid (hit_mid),
        .hit_end (hit_end)
    );

    rx_shift #(.WIDTH(DATA_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (shift_en),
        .bit_in (rx_s),
        .q      (shift_q)
    );

    assign cnt_clr  = (state == S_IDLE) || (state == S_START && hit_mid);
    assign shift_en = (state == S_DATA) && hit_end;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (!rx_s)                   nxt = S_START;
            S_START:     if (hit_mid)                 nxt = rx_s ? S_IDLE : S_DATA;
            S_DATA:      if (hit_end && bit_idx == LAST_IDX) nxt = S_STOP;
            S_STOP:      if (hit_end)                 nxt = S_WAIT_HIGH;
            S_WAIT_HIGH: if (rx_s)                    nxt = S_IDLE;
            default:                                  nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Data-bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bit_idx <= '0;
        else if (state != S_DATA)  bit_idx <= '0;
        else if (hit_end)          bit_idx <= bit_idx + 1'b1;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out   <= '0;
            data_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            if (state == S_STOP && hit_end) begin
                data_out   <= shift_q;
                data_valid <= 1'b1;
                frame_err  <= ~rx_s;
            end
        end
    end

    // One strobe per character
    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // A strobe only follows the stop-bit state
    p_valid_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(state) == S_STOP);

    // Data phase entered only when the start-centre sample was low
    p_start_confirmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && $past(state) == S_START) |-> !$past(rx_s));

    // Rearm only after the line was seen high
    p_rearm_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state) == S_WAIT_HIGH) |-> $past(rx_s));

    // Stop phase follows the last data bit
    p_stop_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP && $past(state) == S_DATA) |-> $past(bit_idx) == LAST_IDX);
endmodule

// File: tb/uart_rx_front_test.sv
module uart_rx_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLK    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] data_out;
    logic       data_valid;
    logic       frame_err;

    int tests = 0;
    int fails = 0;
    int tdiv = 0;
    logic prev_valid = 1'b0;
    logic [8:0] expq[$];
    logic [7:0] last_data = 8'h00;
    logic       last_ferr = 1'b0;

    uart_rx_front uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxd        (rxd),
        .data_out   (data_out),
        .data_valid (data_valid),
        .frame_err  (frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Tick generator: one cycle high every TICK_DIV clocks
    always @(negedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TICK_DIV - 1);
    end

    // Reference comparison on every clock: any strobe must match the queue head
    always @(negedge clk) begin
        if (rst_n) begin
            if (data_valid && prev_valid) begin
                tests++; fails++;
                $display("FAIL R2: strobe longer than one cycle, actual 2 expected 1");
            end
            if (data_valid && !prev_valid) begin
                tests++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R3/R6: spurious character actual %h expected none", data_out);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    if ({frame_err, data_out} !== e) begin
                        fails++;
                        $display("FAIL R2/R5: character actual ferr=%0b data=%h expected ferr=%0b data=%h",
                                 frame_err, data_out, e[8], e[7:0]);
                    end
                    last_data = e[7:0];
                    last_ferr = e[8];
                end
            end
            prev_valid <= data_valid;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic v, input int n);
        rxd = v;
        wait_clk(n);
    endtask

    // Sends one frame; edge_noise inverts each data bit in its first and last 3 ticks
    task automatic send(input logic [7:0] d, input logic stop, input logic edge_noise);
        expq.push_back({~stop, d});
        drive(1'b0, BIT_CLK);
        for (int b = 0; b < 8; b++) begin
            for (int c = 0; c < BIT_CLK; c++) begin
                if (edge_noise && (c < 3 * TICK_DIV || c >= BIT_CLK - 3 * TICK_DIV))
                    rxd = ~d[b];
                else
                    rxd = d[b];
                @(negedge clk);
            end
        end
        drive(stop, BIT_CLK);
    endtask

    task automatic check_drained(input string req);
        tests++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL %s: missing characters actual %0d pending expected 0", req, expq.size());
            expq.delete();
        end
    endtask

    task automatic check_held(input string req);
        tests++;
        if (data_out !== last_data || frame_err !== last_ferr) begin
            fails++;
            $display("FAIL %s: held outputs actual %h/%0b expected %h/%0b",
                     req, data_out, frame_err, last_data, last_ferr);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        // R1 reset state
        tests++;
        if (data_valid !== 1'b0) begin fails++; $display("FAIL R1: data_valid actual %0b expected 0", data_valid); end
        tests++;
        if (data_out !== 8'h00) begin fails++; $display("FAIL R1: data_out actual %h expected 00", data_out); end
        tests++;
        if (frame_err !== 1'b0) begin fails++; $display("FAIL R1: frame_err actual %0b expected 0", frame_err); end
        rst_n = 1'b1;
        wait_clk(3 * BIT_CLK);

        // R2 several byte patterns
        send(8'hA5, 1'b1, 1'b0); drive(1'b1, BIT_CLK);
        send(8'h3C, 1'b1, 1'b0); drive(1'b1, BIT_CLK);
        send(8'h00, 1'b1, 1'b0); drive(1'b1, BIT_CLK);
        send(8'hFF, 1'b1, 1'b0); drive(1'b1, BIT_CLK);
        check_drained("R2");

        // R3 short low pulses are rejected; R7 outputs held
        drive(1'b0, 4 * TICK_DIV); drive(1'b1, 12 * BIT_CLK);
        drive(1'b0, 5 * TICK_DIV); drive(1'b1, 12 * BIT_CLK);
        check_drained("R3");
        check_held("R7");

        // R4 mid-bit sampling tolerates disturbed bit edges
        send(8'h5A, 1'b1, 1'b1); drive(1'b1, BIT_CLK);
        send(8'hC3, 1'b1, 1'b1); drive(1'b1, BIT_CLK);
        check_drained("R4");

        // R5 framing error still delivers the byte
        send(8'h81, 1'b0, 1'b0); drive(1'b1, 2 * BIT_CLK);
        check_drained("R5");
        check_held("R5");

        // R6 line held low after a framing error yields nothing until high
        send(8'h7E, 1'b0, 1'b0);
        drive(1'b0, 5 * BIT_CLK);
        check_drained("R6");
        drive(1'b1, 2 * BIT_CLK);
        send(8'h42, 1'b1, 1'b0); drive(1'b1, BIT_CLK);
        check_drained("R6");

        // R8 back-to-back frames
        send(8'h12, 1'b1, 1'b0);
        send(8'h34, 1'b1, 1'b0);
        send(8'hE7, 1'b1, 1'b0);
        drive(1'b1, 2 * BIT_CLK);
        check_drained("R8");
        check_held("R7");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule